// File: doc/BRIEF.md
# DRAM Delay-Locked-Loop Reset and Mode Sequencer

This block sits on the controller side of a low-latency DRAM interface. When asked to (re)start, it emits two mode-register-set strobes. Each strobe carries a mode word built from the controller's option inputs: multiplexed addressing, the source of output impedance, and on-die termination. The first strobe leaves the DLL control bit clear. The second strobe, issued at least a mode-register cycle time later, sets that bit.

After the second strobe, the sequencer withholds read permission for a fixed lock interval so that the device clock can settle. Host read requests that arrive while permission is withheld are counted, not discarded. They are released one per cycle once permission returns.

A start request that arrives at any point, including in the middle of a sequence, abandons the count in progress. The sequence then begins again from the clearing strobe.

Top module: `dram_dll_seq`

## Requirements
- R1: After synchronous reset, `mrs_o`, `mode_o`, `rd_permit_o` and `rd_go_o` are all 0. No strobe is issued until `start_i` is seen.
- R2: In the cycle after `start_i` is sampled high, `mrs_o` is 1 and `mode_o[7]` (DLL control bit) is 0.
- R3: The second strobe, with `mode_o[7]` = 1, comes exactly `MRSC` cycles after the clearing strobe. No strobe is issued in between.
- R4: `rd_permit_o` is 0 from the clearing strobe onward. It rises exactly `LOCK_CYC` cycles after the DLL-setting strobe.
- R5: During a strobe, `mode_o[5]` equals `cfg_mux_i`, `mode_o[8]` equals `cfg_extz_i` and `mode_o[9]` equals `cfg_odt_i`, all taken in that same cycle. Every other bit is 0 during a strobe, and the whole word is 0 when no strobe is active.
- R6: While `rd_permit_o` is 1 and no read is held, a request on `rd_req_i` produces `rd_go_o` = 1 in the same cycle.
- R7: Requests made while `rd_permit_o` is 0 are held, up to 2^`PEND_W`-1 of them. They are issued on `rd_go_o`, one per cycle, beginning in the first cycle of permission.
- R8: A `start_i` arriving in the gap, the lock wait or the permitted state restarts the sequence. The next cycle is a clearing strobe, permission is dropped, and all R3/R4 timing is measured afresh.
- R9: Held read requests survive a restart and are released after the restarted lock interval.
- R10: Once permitted, `rd_permit_o` stays 1 and no strobe appears until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run (or rerun) the DLL reset sequence |
| cfg_mux_i | input | 1 | Select multiplexed address mode |
| cfg_extz_i | input | 1 | Select external-resistor output impedance (0: internal driver) |
| cfg_odt_i | input | 1 | Enable on-die termination |
| rd_req_i | input | 1 | Host read request, one per cycle high |
| mrs_o | output | 1 | Mode-register-set command strobe |
| mode_o | output | MODE_W | Mode word accompanying the strobe |
| rd_permit_o | output | 1 | Reads may issue |
| rd_go_o | output | 1 | A read issues this cycle |

## Verification
If the sequencer is in the wrong state, the fault is visible at once on `mrs_o` or `rd_permit_o`. A missing strobe, an extra strobe, or one in the wrong cycle shows up in the very cycle it occurs. The same is true of permission that opens early.

A wrong value in the interval counter is only exposed when the counter finishes. For that reason every lock and gap window is checked against its exact edge cycle: permission must be low in the final withheld cycle and high in the next one.

A fault in the held-request count appears as too few or too many `rd_go_o` pulses after permission opens. The bench therefore counts those pulses in the cycles right after the rise.

// File: rtl/dram_dll_seq_pkg.sv
package dram_dll_seq_pkg;

    // Positions the device decodes inside the mode word.
    localparam int unsigned POS_MUX  = 5;
    localparam int unsigned POS_DLL  = 7;
    localparam int unsigned POS_ZSRC = 8;
    localparam int unsigned POS_ODT  = 9;

    typedef struct packed {
        logic mux;
        logic zsrc;
        logic odt;
    } mode_opts_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_GAP,
        ST_SET,
        ST_LOCK,
        ST_RUN
    } seq_state_t;

    // Value of one mode word bit for a given option set and DLL control.
    function automatic logic mode_bit(input int unsigned pos,
                                      input mode_opts_t opts,
                                      input logic dll_on);
        logic b;
        case (pos)
            POS_MUX:  b = opts.mux;
            POS_DLL:  b = dll_on;
            POS_ZSRC: b = opts.zsrc;
            POS_ODT:  b = opts.odt;
            default:  b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dram_mode_word.sv
module dram_mode_word
    import dram_dll_seq_pkg::*;
#(
    parameter int unsigned MODE_W = 18
) (
    input  logic              strobe_i,
    input  logic              dll_on_i,
    input  mode_opts_t        opts_i,
    output logic [MODE_W-1:0] word_o
);

    // Each bit is qualified by the strobe so the word is quiet between commands.
    for (genvar i = 0; i < MODE_W; i++) begin : g_bit
        assign word_o[i] = strobe_i & mode_bit(i, opts_i, dll_on_i);
    end

endmodule

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Final cycle of the window: the owner moves on at the next edge.
    assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dram_rd_gate.sv
module dram_rd_gate #(
    parameter int unsigned PEND_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic permit_i,
    input  logic req_i,
    output logic go_o
);

    logic [PEND_W-1:0] pend_q;

    assign go_o = permit_i && (req_i || (pend_q != '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            case ({req_i, go_o})
                2'b10:   pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    // R7: a request that must be held never finds the counter full.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (req_i && !go_o) |-> (pend_q != '1));

endmodule

// File: rtl/dram_dll_seq.sv
module dram_dll_seq
    import dram_dll_seq_pkg::*;
#(
    parameter int unsigned MODE_W   = 18,
    parameter int unsigned MRSC     = 4,
    parameter int unsigned LOCK_CYC = 1024,
    parameter int unsigned PEND_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cfg_mux_i,
    input  logic              cfg_extz_i,
    input  logic              cfg_odt_i,
    input  logic              rd_req_i,
    output logic              mrs_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              rd_permit_o,
    output logic              rd_go_o
);

    localparam int unsigned SPAN  = (MRSC > LOCK_CYC) ? MRSC : LOCK_CYC;
    localparam int unsigned CNT_W = $clog2(SPAN + 1);
    localparam logic [CNT_W-1:0] GAP_LOAD  = CNT_W'(MRSC - 1);
    localparam logic [CNT_W-1:0] LOCK_LOAD = CNT_W'(LOCK_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_MIN   = CNT_W'(MRSC);
    localparam logic [CNT_W-1:0] LOCK_MIN  = CNT_W'(LOCK_CYC);

    seq_state_t       state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             dll_on;
    mode_opts_t       opts;

    // Sequencing: a start request overrides every state.
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_CLR;
        end else begin
            case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_CLR:  state_d = ST_GAP;
                ST_GAP:  if (tmr_last) state_d = ST_SET;
                ST_SET:  state_d = ST_LOCK;
                ST_LOCK: if (tmr_last) state_d = ST_RUN;
                ST_RUN:  state_d = ST_RUN;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign tmr_load    = (state_q == ST_CLR) || (state_q == ST_SET);
    assign tmr_val     = (state_q == ST_CLR) ? GAP_LOAD : LOCK_LOAD;
    assign mrs_o       = tmr_load;
    assign dll_on      = (state_q == ST_SET);
    assign rd_permit_o = (state_q == ST_RUN);

    assign opts.mux  = cfg_mux_i;
    assign opts.zsrc = cfg_extz_i;
    assign opts.odt  = cfg_odt_i;

    dram_seq_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .last_o (tmr_last)
    );

    dram_mode_word #(
        .MODE_W (MODE_W)
    ) word_i (
        .strobe_i (mrs_o),
        .dll_on_i (dll_on),
        .opts_i   (opts),
        .word_o   (mode_o)
    );

    dram_rd_gate #(
        .PEND_W (PEND_W)
    ) gate_i (
        .clk      (clk),
        .rst      (rst),
        .permit_i (rd_permit_o),
        .req_i    (rd_req_i),
        .go_o     (rd_go_o)
    );

    // Checking windows measured at the ports, independent of the FSM timer.
    logic [CNT_W-1:0] gap_seen_q;
    logic [CNT_W-1:0] lock_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_seen_q  <= '0;
            lock_seen_q <= '0;
        end else begin
            if (mrs_o && !mode_o[POS_DLL]) begin
                gap_seen_q <= CNT_W'(1);
            end else if (gap_seen_q != '0 && gap_seen_q < GAP_MIN) begin
                gap_seen_q <= gap_seen_q + 1'b1;
            end
            if (mrs_o && !mode_o[POS_DLL]) begin
                lock_seen_q <= '0;
            end else if (mrs_o && mode_o[POS_DLL]) begin
                lock_seen_q <= CNT_W'(1);
            end else if (lock_seen_q != '0 && lock_seen_q < LOCK_MIN) begin
                lock_seen_q <= lock_seen_q + 1'b1;
            end
        end
    end

    p_mrs_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        (mrs_o && mode_o[POS_DLL]) |-> (gap_seen_q >= GAP_MIN));

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        (mrs_o && !start_i) |=> !mrs_o);

    p_lock_wait_r4: assert property (@(posedge clk) disable iff (rst)
        rd_permit_o |-> (lock_seen_q >= LOCK_MIN));

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (mrs_o && !mode_o[POS_DLL] && !rd_permit_o));

    p_run_steady_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_permit_o && !start_i) |=> (rd_permit_o && !mrs_o));

endmodule

// File: tb/dram_dll_seq_tb_top.sv
`timescale 1ns/1ps
module dram_dll_seq_tb_top;

    localparam int MODE_W = 18;
    localparam int MRSC   = 4;
    localparam int LOCK   = 1024;
    localparam int PEND_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic cfg_mux_i = 1'b0, cfg_extz_i = 1'b0, cfg_odt_i = 1'b0;
    logic rd_req_i = 1'b0;
    logic mrs_o, rd_permit_o, rd_go_o;
    logic [MODE_W-1:0] mode_o;

    int checks = 0;
    int errors = 0;

    // {mux, extz, odt} followed by the expected word of the clearing strobe (R5).
    localparam logic [20:0] VEC [8] = '{
        {3'b000, 18'h00000},
        {3'b100, 18'h00020},
        {3'b010, 18'h00100},
        {3'b001, 18'h00200},
        {3'b110, 18'h00120},
        {3'b101, 18'h00220},
        {3'b011, 18'h00300},
        {3'b111, 18'h00320}
    };

    always #4 clk = ~clk;

    dram_dll_seq #(
        .MODE_W   (MODE_W),
        .MRSC     (MRSC),
        .LOCK_CYC (LOCK),
        .PEND_W   (PEND_W)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .cfg_mux_i   (cfg_mux_i),
        .cfg_extz_i  (cfg_extz_i),
        .cfg_odt_i   (cfg_odt_i),
        .rd_req_i    (rd_req_i),
        .mrs_o       (mrs_o),
        .mode_o      (mode_o),
        .rd_permit_o (rd_permit_o),
        .rd_go_o     (rd_go_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [2:0] c);
        {cfg_mux_i, cfg_extz_i, cfg_odt_i} = c;
    endtask

    // Leaves the bench in the clearing-strobe cycle.
    task automatic start_seq();
        start_i = 1'b1;
        cyc();
        start_i = 1'b0;
    endtask

    // Entered in the set-strobe cycle; leaves in the first permitted cycle.
    task automatic lock_wait();
        int bad = 0;
        for (int k = 1; k < LOCK; k++) begin
            cyc();
            if (rd_permit_o !== 1'b0 || mrs_o !== 1'b0) bad++;
        end
        chk("R4", "permit low through final lock cycle", bad, 0);
        cyc();
        chk("R4", "permit at lock end", rd_permit_o, 1);
    endtask

    // Entered in the clearing-strobe cycle; leaves in the first permitted cycle.
    task automatic seq_check(input logic [17:0] clr_w, input logic [17:0] set_w);
        int extra = 0;
        chk("R2", "clear strobe", mrs_o, 1);
        chk("R2", "clear word", mode_o, clr_w);
        chk("R4", "permit dropped at clear", rd_permit_o, 0);
        for (int k = 1; k < MRSC; k++) begin
            cyc();
            if (mrs_o !== 1'b0) extra++;
        end
        chk("R3", "no strobe in gap", extra, 0);
        cyc();
        chk("R3", "set strobe after gap", mrs_o, 1);
        chk("R5", "set word", mode_o, set_w);
        lock_wait();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk("R1", "mrs after reset", mrs_o, 0);
        chk("R1", "mode after reset", mode_o, 0);
        chk("R1", "permit after reset", rd_permit_o, 0);
        chk("R1", "go after reset", rd_go_o, 0);
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            cyc();
            if (mrs_o !== 1'b0 || mode_o !== '0) cnt++;
        end
        chk("R1", "idle without start", cnt, 0);

        // Table walk: every option combination; later entries restart from run (R8).
        for (int i = 0; i < 8; i++) begin
            set_cfg(VEC[i][20:18]);
            start_seq();
            seq_check(VEC[i][17:0], VEC[i][17:0] | 18'h00080);
        end

        // R10 steady permitted state
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            cyc();
            if (rd_permit_o !== 1'b1 || mrs_o !== 1'b0) cnt++;
        end
        chk("R10", "permit steady, no strobe", cnt, 0);

        // R6 immediate read when permitted
        rd_req_i = 1'b1;
        #1;
        chk("R6", "same-cycle go", rd_go_o, 1);
        cyc();
        rd_req_i = 1'b0;
        #1;
        chk("R6", "no extra go", rd_go_o, 0);

        // R5 options taken at each strobe; R7 reads held during lock
        set_cfg(3'b000);
        start_seq();
        chk("R5", "word with options off", mode_o, 18'h00000);
        set_cfg(3'b111);
        for (int k = 1; k < MRSC; k++) cyc();
        cyc();
        chk("R5", "word follows new options", mode_o, 18'h003A0);
        cnt = 0;
        for (int k = 1; k < LOCK; k++) begin
            cyc();
            rd_req_i = (k == 10 || k == 20 || k == 30);
            #1;
            if (rd_go_o !== 1'b0) cnt++;
        end
        chk("R7", "no go while withheld", cnt, 0);
        cyc();
        rd_req_i = 1'b0;
        #1;
        chk("R4", "permit after lock", rd_permit_o, 1);
        chk("R7", "held read 1", rd_go_o, 1);
        cyc();
        chk("R7", "held read 2", rd_go_o, 1);
        cyc();
        chk("R7", "held read 3", rd_go_o, 1);
        cyc();
        chk("R7", "held reads drained", rd_go_o, 0);

        // R8 restart mid-lock with R9 held reads kept
        start_seq();
        for (int k = 1; k < MRSC; k++) cyc();
        cyc();
        for (int k = 1; k <= 100; k++) begin
            cyc();
            rd_req_i = (k == 5 || k == 6);
            start_i  = (k == 100);
        end
        cyc();
        start_i = 1'b0;
        chk("R8", "permit low after abort", rd_permit_o, 0);
        seq_check(18'h00320, 18'h003A0);
        chk("R9", "held read 1 after restart", rd_go_o, 1);
        cyc();
        chk("R9", "held read 2 after restart", rd_go_o, 1);
        cyc();
        chk("R9", "held reads drained", rd_go_o, 0);

        // R8 restart inside the gap
        start_seq();
        cyc();
        cyc();
        start_i = 1'b1;
        cyc();
        start_i = 1'b0;
        chk("R8", "restart strobe clears DLL bit", mode_o[7], 0);
        seq_check(18'h00320, 18'h003A0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule